// File: doc/BRIEF.md
# Serial Receiver Reset Sequencer

This block brings a source-synchronous serial receiver out of reset in a fixed order, on the receiver's parallel clock. It first holds the receiver PLL in reset for a short pulse. Once the PLL reports lock, it pulses the datapath reset. Once dynamic phase alignment reports lock, it pulses the receive FIFO reset. After that last pulse it settles in an operating state and raises a ready flag.

Both lock flags arrive asynchronously, so each one passes through a short synchronizer before the state machine uses it. If a lock drops later, the sequencer goes back to the stage that depends on that lock and does not restart from idle. PLL lock loss goes back to the PLL reset stage. Phase-alignment lock loss goes back to the datapath reset stage. The system reset input is synchronous and active high, and it returns the block to idle with every reset output asserted.

No data passes through the block. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure.

Top module: `rx_bringup_seq`

## Requirements
- R1: While `rst` is high, `pll_rst_o`, `dp_rst_o` and `fifo_rst_o` are high and `ready_o` is low. On the first clock edge with `rst` low, the sequencer leaves idle and enters the PLL-reset stage, whatever the lock inputs are.
- R2: `pll_rst_o` is high in idle and for exactly the first `PULSE_CYCLES` cycles of every visit to the PLL-reset stage. After that it is low until the stage is left and entered again.
- R3: The sequencer moves from the PLL-reset stage to the datapath-reset stage only when the PLL pulse has finished and the synchronized PLL lock is high. `dp_rst_o` is high in idle, throughout the PLL-reset stage, and for the first `PULSE_CYCLES` cycles of the datapath-reset stage.
- R4: The sequencer moves from the datapath-reset stage to the FIFO-reset stage only when the datapath pulse has finished and the synchronized alignment lock is high. `fifo_rst_o` is high in every earlier stage and for the first `PULSE_CYCLES` cycles of the FIFO-reset stage.
- R5: The FIFO-reset stage is the operating stage. The sequencer stays there for as long as both synchronized locks stay high.
- R6: When the synchronized PLL lock is low in the datapath-reset or FIFO-reset stage, the next state is the PLL-reset stage. Its pulse counter starts again from zero, so `pll_rst_o` pulses again.
- R7: When the synchronized alignment lock is low in the FIFO-reset stage while the PLL lock is still high, the next state is the datapath-reset stage, and `dp_rst_o` pulses again.
- R8: When both synchronized locks are low in the same cycle in the FIFO-reset stage, PLL lock loss wins: the sequencer goes to the PLL-reset stage.
- R9: `ready_o` is high only when all of the following hold: the FIFO pulse has finished, both synchronized locks are high, and `rst` is low. It drops in the same cycle that either synchronized lock drops or `rst` rises.
- R10: A change on `pll_lock_i` or `align_lock_i` reaches the state machine after `SYNC_STAGES` clock edges. A lock pulse one cycle long is still seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver parallel clock |
| rst | input | 1 | Synchronous system reset, active high |
| pll_lock_i | input | 1 | Receiver PLL lock flag, asynchronous |
| align_lock_i | input | 1 | Dynamic phase-alignment lock flag, asynchronous |
| pll_rst_o | output | 1 | Receiver PLL reset, active high |
| dp_rst_o | output | 1 | Receiver datapath reset, active high |
| fifo_rst_o | output | 1 | Receiver FIFO reset, active high |
| ready_o | output | 1 | Receiver is up and both locks are held |

## Verification
The bench builds the block with `PULSE_CYCLES` = 3 and `SYNC_STAGES` = 3, both different from the defaults. A pulse-length counter or a synchronizer depth that ignores its parameter therefore changes the cycle in which the outputs move. With these values the bench can reach a lock that arrives while its pulse is still running, and a lock glitch one cycle long that has to cross the deeper synchronizer. It can also reach a single-lock loss and a simultaneous loss of both locks, in both the datapath-reset and the operating stage.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PLL  = 2'd1,
    ST_DP   = 2'd2,
    ST_FIFO = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rxseq_lock_sync.sv
module rxseq_lock_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_async;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= '0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rxseq_pulse_timer.sv
module rxseq_pulse_timer #(
  parameter int PULSE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic done
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PULSE_CYCLES);

  logic [CW-1:0] cnt;

  assign done = (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (!done)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rxseq_fsm.sv
module rxseq_fsm
  import rxseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pll_lk,
  input  logic       al_lk,
  input  logic       pulse_done,
  output seq_state_t st,
  output logic       enter
);
  seq_state_t st_nxt;

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE: st_nxt = ST_PLL;
      ST_PLL:  if (pulse_done && pll_lk) st_nxt = ST_DP;
      ST_DP: begin
        if (!pll_lk)                  st_nxt = ST_PLL;
        else if (pulse_done && al_lk) st_nxt = ST_FIFO;
      end
      ST_FIFO: begin
        if (!pll_lk)     st_nxt = ST_PLL;
        else if (!al_lk) st_nxt = ST_DP;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign enter = (st_nxt != st);

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end
endmodule

// File: rtl/rx_bringup_seq.sv
module rx_bringup_seq
  import rxseq_pkg::*;
#(
  parameter int PULSE_CYCLES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pll_lock_i,
  input  logic align_lock_i,
  output logic pll_rst_o,
  output logic dp_rst_o,
  output logic fifo_rst_o,
  output logic ready_o
);
  localparam int NLOCK = 2;

  logic [NLOCK-1:0] lk_s;
  logic             pll_lk_s, al_lk_s;
  logic             pulse_done, enter;
  seq_state_t       st;

  rxseq_lock_sync #(.WIDTH(NLOCK), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({align_lock_i, pll_lock_i}),
    .q_sync  (lk_s)
  );

  assign pll_lk_s = lk_s[0];
  assign al_lk_s  = lk_s[1];

  rxseq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .pll_lk     (pll_lk_s),
    .al_lk      (al_lk_s),
    .pulse_done (pulse_done),
    .st         (st),
    .enter      (enter)
  );

  rxseq_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (enter),
    .done    (pulse_done)
  );

  // Each reset stays high through every stage before its own,
  // then is released once the pulse of its own stage has run out.
  always_comb begin
    pll_rst_o  = rst || (st == ST_IDLE) || (st == ST_PLL && !pulse_done);
    dp_rst_o   = rst || (st == ST_IDLE) || (st == ST_PLL)
                     || (st == ST_DP && !pulse_done);
    fifo_rst_o = rst || (st != ST_FIFO) || !pulse_done;
    ready_o    = !rst && (st == ST_FIFO) && pulse_done && pll_lk_s && al_lk_s;
  end
endmodule

// File: rtl/rx_bringup_seq_chk.sv
module rx_bringup_seq_chk
  import rxseq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       pll_rst_o,
  input logic       dp_rst_o,
  input logic       fifo_rst_o,
  input logic       ready_o,
  input logic       pll_lk_s,
  input logic       al_lk_s,
  input seq_state_t st
);
  assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pll_rst_o && dp_rst_o && fifo_rst_o && !ready_o));

  assert_pll_release_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_rst_o) |-> (dp_rst_o && fifo_rst_o));

  assert_dp_release_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(dp_rst_o) |-> (fifo_rst_o && !pll_rst_o));

  assert_fifo_release_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(fifo_rst_o) |-> (!pll_rst_o && !dp_rst_o));

  assert_hold_operating_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FIFO && pll_lk_s && al_lk_s) |=> (st == ST_FIFO));

  assert_pll_loss_R6: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_DP || st == ST_FIFO) && !pll_lk_s) |=> (st == ST_PLL && pll_rst_o));

  assert_align_loss_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FIFO && pll_lk_s && !al_lk_s) |=> (st == ST_DP && dp_rst_o));

  assert_both_loss_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FIFO && !pll_lk_s && !al_lk_s) |=> (st == ST_PLL));

  assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (!pll_rst_o && !dp_rst_o && !fifo_rst_o && pll_lk_s && al_lk_s));
endmodule

bind rx_bringup_seq rx_bringup_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .pll_rst_o  (pll_rst_o),
  .dp_rst_o   (dp_rst_o),
  .fifo_rst_o (fifo_rst_o),
  .ready_o    (ready_o),
  .pll_lk_s   (pll_lk_s),
  .al_lk_s    (al_lk_s),
  .st         (st)
);

// File: tb/rx_bringup_seq_tb.sv
module rx_bringup_seq_tb;
  localparam int P = 3;
  localparam int S = 3;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pll_lock_i = 1'b0;
  logic align_lock_i = 1'b0;
  logic pll_rst_o, dp_rst_o, fifo_rst_o, ready_o;

  rx_bringup_seq #(.PULSE_CYCLES(P), .SYNC_STAGES(S)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .pll_lock_i   (pll_lock_i),
    .align_lock_i (align_lock_i),
    .pll_rst_o    (pll_rst_o),
    .dp_rst_o     (dp_rst_o),
    .fifo_rst_o   (fifo_rst_o),
    .ready_o      (ready_o)
  );

  always #5 clk = ~clk;

  // Reference model: stage 0 idle, 1 PLL reset, 2 datapath reset, 3 operating.
  int    m_stage = 0;
  int    m_age   = 0;
  bit    pq[$];
  bit    aq[$];
  int    vectors = 0;
  int    errors  = 0;
  int    cycles  = 0;
  string ph      = "R1";
  bit    done    = 1'b0;

  initial begin
    for (int i = 0; i < S; i++) begin
      pq.push_back(1'b0);
      aq.push_back(1'b0);
    end
  end

  always @(posedge clk) begin
    bit pl, al;
    int nxt;
    pl = pq[S-1];
    al = aq[S-1];
    if (rst) begin
      m_stage = 0;
      m_age   = 0;
      for (int i = 0; i < S; i++) begin
        pq[i] = 1'b0;
        aq[i] = 1'b0;
      end
    end else begin
      nxt = m_stage;
      if (m_stage == 0) nxt = 1;
      else if (m_stage == 1) begin
        if (m_age >= P && pl) nxt = 2;
      end else if (m_stage == 2) begin
        if (!pl) nxt = 1;
        else if (m_age >= P && al) nxt = 3;
      end else begin
        if (!pl) nxt = 1;
        else if (!al) nxt = 2;
      end
      if (nxt != m_stage) m_age = 0;
      else if (m_age < P) m_age++;
      m_stage = nxt;
      pq.push_front(pll_lock_i);
      void'(pq.pop_back());
      aq.push_front(align_lock_i);
      void'(aq.pop_back());
    end
  end

  task automatic cmp(input string name, input logic act, input logic exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", ph, name, cycles, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    cycles++;
    if (!done) begin
      vectors++;
      cmp("pll_rst_o",  pll_rst_o,  rst || m_stage == 0 || (m_stage == 1 && m_age < P));
      cmp("dp_rst_o",   dp_rst_o,   rst || m_stage <= 1 || (m_stage == 2 && m_age < P));
      cmp("fifo_rst_o", fifo_rst_o, rst || m_stage <= 2 || m_age < P);
      cmp("ready_o",    ready_o,    !rst && m_stage == 3 && m_age >= P && pq[S-1] && aq[S-1]);
      if (cycles > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog expired, actual running expected finished");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset with both locks high; the outputs must stay asserted
    ph = "R1";
    pll_lock_i = 1'b1;
    align_lock_i = 1'b1;
    wait_cyc(4);
    rst = 1'b0;
    // R2 / R3: lock already present, still waits for the PLL pulse
    ph = "R2_R3";
    wait_cyc(20);
    // R5 / R9: operating and ready
    ph = "R5_R9";
    wait_cyc(6);
    // R7: alignment lost in operating stage
    ph = "R7";
    align_lock_i = 1'b0;
    wait_cyc(8);
    // R4: alignment returns late, datapath pulse long done
    ph = "R4";
    align_lock_i = 1'b1;
    wait_cyc(12);
    // R6: PLL lost in operating stage, held off for a while
    ph = "R6";
    pll_lock_i = 1'b0;
    wait_cyc(10);
    pll_lock_i = 1'b1;
    wait_cyc(14);
    // R6: PLL lost during datapath-reset stage
    align_lock_i = 1'b0;
    wait_cyc(8);
    pll_lock_i = 1'b0;
    wait_cyc(6);
    pll_lock_i = 1'b1;
    align_lock_i = 1'b1;
    wait_cyc(20);
    // R8: both locks lost in the same cycle
    ph = "R8";
    pll_lock_i = 1'b0;
    align_lock_i = 1'b0;
    wait_cyc(7);
    pll_lock_i = 1'b1;
    align_lock_i = 1'b1;
    wait_cyc(20);
    // R10: single-cycle PLL lock glitch must be seen after the sync delay
    ph = "R10";
    pll_lock_i = 1'b0;
    wait_cyc(1);
    pll_lock_i = 1'b1;
    wait_cyc(20);
    // R3: PLL lock absent after reset, sequencer must park in PLL reset
    ph = "R1_R3";
    rst = 1'b1;
    pll_lock_i = 1'b0;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(12);
    pll_lock_i = 1'b1;
    wait_cyc(20);
    // R9: reset in the operating stage drops ready at once
    ph = "R1_R9";
    rst = 1'b1;
    wait_cyc(2);
    rst = 1'b0;
    wait_cyc(20);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule